// File: doc/BRIEF.md
# Serial Frame Scheduler with Burst Clock Gating

This block sets the frame timing of a 16-bit serial port. A free-running phase counter marks the start of a data frame once every `PERIOD` serial-clock cycles. Between two data frames the block may add one control frame. In automatic mode it adds one in every interval. In requested mode it adds one only when a request flag was high at the data-frame start. The control frame begins either halfway through the interval or a quarter of the way in.

Each frame start produces a one-cycle `fsync` pulse. `frame_kind` tells a data frame (0) from a control frame (1). The block also drives a serial clock enable and a gated serial clock. The gating can run free, or it can open in a burst of 32 cycles after each sync and stay shut until the next one. The mode, request, position and gating inputs are all captured in the data-frame start cycle. A change in the middle of an interval therefore never alters the frames of that interval. Bit shifting is left to the neighbouring serializer.

Top module: `frame_sched`

## Requirements
- R1: After reset is released, `fsync` pulses for one cycle in the first clock cycle and then every `PERIOD` cycles (default 256). Each of these data-frame pulses shows `frame_kind` = 0.
- R2: With `auto_ctl` = 1 at a data-frame start, exactly one control-frame sync follows before the next data-frame sync.
- R3: With `auto_ctl` = 0 at a data-frame start, a control-frame sync follows in that interval only if `ctl_req` was 1 in that start cycle. Otherwise none follows.
- R4: An interval holds at most one control-frame sync, even when `auto_ctl` and `ctl_req` are both high. A data sync and a control sync never fall in the same cycle.
- R5: With `late_pos` = 0 at the data-frame start, the control sync comes `PERIOD`/2 cycles after the data sync.
- R6: With `late_pos` = 1 at the data-frame start, the control sync comes `PERIOD`/4 cycles after the data sync.
- R7: `frame_kind` is 1 from a control sync until the next data sync, and 0 from a data sync until a control sync.
- R8: With `burst_mode` = 1 captured at the data-frame start, `sclk_en` is high in each sync cycle and the 31 cycles after it, and low from then until the next sync.
- R9: With `burst_mode` = 0 captured at the data-frame start, `sclk_en` stays high for the whole interval, so `sclk_o` runs continuously.
- R10: A change of `auto_ctl`, `ctl_req`, `late_pos` or `burst_mode` after the data-frame start cycle has no effect on syncs, `frame_kind` or `sclk_en` before the next data-frame start.
- R11: While `rst_n` is low, `fsync` = 0, `frame_kind` = 0 and `sclk_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_ctl | input | 1 | 1: control frame in every interval; 0: only on request |
| ctl_req | input | 1 | Control frame request, captured at data-frame start |
| late_pos | input | 1 | 0: control frame at half interval; 1: at quarter interval |
| burst_mode | input | 1 | 1: burst-gate the serial clock; 0 (idle default): free run |
| sclk_o | output | 1 | Gated serial clock |
| sclk_en | output | 1 | Serial clock enable, one per `clk` cycle |
| fsync | output | 1 | One-cycle frame sync before bit 15 |
| frame_kind | output | 1 | 0 = data frame, 1 = control frame |

## Verification
The bench runs ten intervals, and each interval uses a different mix of mode, request, position and gating. Automatic mode shows that control frames appear without any request. Requested mode, with and without the flag, shows that the request is what gates the frame. Automatic mode with the request also high shows that two causes still give only one control frame. Each interval uses one of the two positions, so the half and quarter offsets are told apart by the exact cycle of the sync. In one interval every input flips partway through, which shows that the inputs are captured only at the frame start. The burst and free-running intervals compare the enable in every cycle, which pins down the 32-cycle window edges around both data and control syncs.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

  // Number of serial clock cycles let through after each frame sync.
  localparam int unsigned BURST_LEN = 32;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_CTRL = 1'b1
  } frame_kind_e;

  // Distance from a data sync to the control sync of the same interval.
  function automatic int unsigned ctl_offset(input int unsigned period, input logic late);
    return late ? (period / 4) : (period / 2);
  endfunction

endpackage

// File: rtl/fsched_timer.sv
module fsched_timer #(
  parameter int unsigned PERIOD = 256,
  localparam int unsigned PW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          data_start
);

  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  // Reset parks at LAST so the first edge after release lands on phase 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= LAST;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign data_start = rst_n && (phase == '0);

endmodule

// File: rtl/fsched_slot.sv
module fsched_slot
  import fsched_pkg::*;
#(
  parameter int unsigned PERIOD = 256,
  localparam int unsigned PW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  logic          data_start,
  input  logic          auto_ctl,
  input  logic          ctl_req,
  input  logic          late_pos,
  output logic          ctl_start,
  output frame_kind_e   frame_kind
);

  localparam logic [PW-1:0] OFF_MID  = PW'(ctl_offset(PERIOD, 1'b0));
  localparam logic [PW-1:0] OFF_LATE = PW'(ctl_offset(PERIOD, 1'b1));

  logic        armed_q;
  logic        late_q;
  frame_kind_e kind_q;
  logic [PW-1:0] slot_off;

  assign slot_off  = late_q ? OFF_LATE : OFF_MID;
  assign ctl_start = armed_q && (phase == slot_off);

  // Capture all choices at the data-frame start; disarm once the slot is used.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      kind_q  <= KIND_DATA;
    end else if (data_start) begin
      armed_q <= auto_ctl | ctl_req;
      late_q  <= late_pos;
      kind_q  <= KIND_DATA;
    end else if (ctl_start) begin
      armed_q <= 1'b0;
      kind_q  <= KIND_CTRL;
    end
  end

  always_comb begin
    if (data_start)     frame_kind = KIND_DATA;
    else if (ctl_start) frame_kind = KIND_CTRL;
    else                frame_kind = kind_q;
  end

endmodule

// File: rtl/fsched_gate.sv
module fsched_gate
  import fsched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic data_start,
  input  logic burst_mode,
  output logic burst_q,
  output logic sclk_en,
  output logic sclk_o
);

  localparam int unsigned CW = $clog2(BURST_LEN);

  logic [CW-1:0] left_q;
  logic          en_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      if (fsync)              left_q <= CW'(BURST_LEN - 1);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
      if (data_start)         burst_q <= burst_mode;
    end
  end

  assign sclk_en = !burst_q || fsync || (left_q != '0);

  // Enable moves only while clk is low, so the AND below cannot glitch.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lat <= 1'b1;
    else        en_lat <= sclk_en;
  end

  assign sclk_o = clk & en_lat;

endmodule

// File: rtl/frame_sched.sv
module frame_sched
  import fsched_pkg::*;
#(
  parameter int unsigned PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_ctl,
  input  logic ctl_req,
  input  logic late_pos,
  input  logic burst_mode,
  output logic sclk_o,
  output logic sclk_en,
  output logic fsync,
  output logic frame_kind
);

  localparam int unsigned PW = $clog2(PERIOD);

  logic [PW-1:0] phase;
  logic          data_start;
  logic          ctl_start;
  logic          burst_q;
  frame_kind_e   kind;

  fsched_timer #(.PERIOD(PERIOD)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .data_start (data_start)
  );

  fsched_slot #(.PERIOD(PERIOD)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .data_start (data_start),
    .auto_ctl   (auto_ctl),
    .ctl_req    (ctl_req),
    .late_pos   (late_pos),
    .ctl_start  (ctl_start),
    .frame_kind (kind)
  );

  assign fsync      = data_start | ctl_start;
  assign frame_kind = kind;

  fsched_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .data_start (data_start),
    .burst_mode (burst_mode),
    .burst_q    (burst_q),
    .sclk_en    (sclk_en),
    .sclk_o     (sclk_o)
  );

endmodule

// File: rtl/frame_sched_chk.sv
module frame_sched_chk #(
  parameter int unsigned PERIOD = 256
) (
  input logic clk,
  input logic rst_n,
  input logic data_start,
  input logic ctl_start,
  input logic fsync,
  input logic frame_kind,
  input logic sclk_en,
  input logic burst_q
);

  int unsigned gap_q;
  int unsigned since_q;
  int unsigned ctl_seen_q;
  logic        seen_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= 0;
      since_q     <= 0;
      ctl_seen_q  <= 0;
      seen_data_q <= 1'b0;
    end else begin
      gap_q   <= data_start ? 0 : gap_q + 1;
      since_q <= fsync ? 0 : ((since_q < 1000) ? since_q + 1 : since_q);
      if (data_start)     ctl_seen_q <= 0;
      else if (ctl_start) ctl_seen_q <= ctl_seen_q + 1;
      if (data_start)     seen_data_q <= 1'b1;
    end
  end

  assert_data_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_data_q && data_start) |-> (gap_q == PERIOD - 1));

  assert_single_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |-> (ctl_seen_q == 0));

  assert_no_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_start && ctl_start));

  assert_kind_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_kind) |-> ctl_start);

  assert_kind_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_kind) |-> data_start);

  assert_burst_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_q && seen_data_q && !fsync && since_q >= 31) |-> !sclk_en);

endmodule

bind frame_sched frame_sched_chk #(.PERIOD(PERIOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_start (data_start),
  .ctl_start  (ctl_start),
  .fsync      (fsync),
  .frame_kind (frame_kind),
  .sclk_en    (sclk_en),
  .burst_q    (burst_q)
);

// File: tb/test_frame_sched.sv
module test_frame_sched;

  localparam int P    = 256;
  localparam int NINT = 10;

  typedef struct {
    int    at;
    bit    kind;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_ctl = 1'b0, ctl_req = 1'b0, late_pos = 1'b0, burst_mode = 1'b0;
  logic sclk_o, sclk_en, fsync, frame_kind;

  always #2.5 clk = ~clk;

  frame_sched #(.PERIOD(P)) i_frame_sched (
    .clk(clk), .rst_n(rst_n), .auto_ctl(auto_ctl), .ctl_req(ctl_req),
    .late_pos(late_pos), .burst_mode(burst_mode), .sclk_o(sclk_o),
    .sclk_en(sclk_en), .fsync(fsync), .frame_kind(frame_kind)
  );

  int  cyc = -1;
  bit  arm_tab[16], late_tab[16], burst_tab[16];
  ev_t expq[$];
  int  n_cmp = 0, n_bad = 0;
  bit  done = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int slot_of(bit late);
    return late ? (P >> 2) : (P >> 1);
  endfunction

  // Driver: applies one interval's inputs and queues the syncs it must cause.
  task automatic plan(int n, bit a, bit r, bit l, bit b);
    ev_t e;
    auto_ctl = a; ctl_req = r; late_pos = l; burst_mode = b;
    arm_tab[n] = a | r; late_tab[n] = l; burst_tab[n] = b;
    e.at = n * P; e.kind = 1'b0; e.tag = "R1";
    expq.push_back(e);
    if (a | r) begin
      e.at = n * P + slot_of(l); e.kind = 1'b1;
      e.tag = l ? "R6" : "R5";
      expq.push_back(e);
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc != c) @(negedge clk);
  endtask

  // Monitor: pops expected syncs and checks kind and clock enable every cycle.
  always @(negedge clk) begin
    if (rst_n && cyc >= 0 && !done) begin
      int  n, r, s;
      bit  ek, ee;
      ev_t e;
      n = cyc / P; r = cyc % P;
      while (expq.size() > 0 && expq[0].at < cyc) begin
        check(1'b0, expq[0].tag, "missing sync at cycle", -1, expq[0].at);
        void'(expq.pop_front());
      end
      ek = arm_tab[n] && (r >= slot_of(late_tab[n]));
      if (fsync) begin
        if (expq.size() == 0) check(1'b0, "R4", "unexpected sync", cyc, -1);
        else begin
          e = expq.pop_front();
          check(e.at == cyc, e.tag, "sync cycle", cyc, e.at);
          check(frame_kind == e.kind, "R7", "kind at sync", frame_kind, e.kind);
        end
      end else begin
        check(frame_kind == ek, "R7", "kind between syncs", frame_kind, ek);
      end
      s  = ek ? slot_of(late_tab[n]) : 0;
      ee = (r == 0) || !burst_tab[n] || ((r - s) < 32);
      check(sclk_en == ee, burst_tab[n] ? "R8" : "R9", "sclk_en", sclk_en, ee);
    end
  end

  initial begin
    plan(0, 0, 0, 0, 0);
    #12;
    check(fsync == 1'b0, "R11", "fsync in reset", fsync, 0);
    check(frame_kind == 1'b0, "R11", "kind in reset", frame_kind, 0);
    check(sclk_en == 1'b1, "R11", "sclk_en in reset", sclk_en, 1);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(1 * P - 1); plan(1, 1, 0, 0, 0);   // R2 automatic, R5 midway
    wait_cyc(2 * P - 1); plan(2, 1, 0, 1, 1);   // R2 automatic, R6 quarter, R8 burst
    wait_cyc(3 * P - 1); plan(3, 0, 1, 1, 1);   // R3 requested
    wait_cyc(4 * P - 1); plan(4, 0, 0, 1, 1);   // R3 no request, no control frame
    wait_cyc(5 * P - 1); plan(5, 0, 1, 0, 0);   // R3 requested, midway
    wait_cyc(6 * P - 1); plan(6, 1, 1, 0, 1);   // R4 both causes, one frame
    wait_cyc(7 * P - 1); plan(7, 0, 0, 0, 1);
    wait_cyc(7 * P + 10);                       // R10 mid-interval flips
    auto_ctl = 1'b1; ctl_req = 1'b1; late_pos = 1'b1; burst_mode = 1'b0;
    wait_cyc(8 * P - 1); plan(8, 1, 1, 1, 0);
    wait_cyc(9 * P - 1); plan(9, 0, 0, 0, 1);
    wait_cyc(NINT * P - 5);
    done = 1'b1;
    check(expq.size() == 0, "R1", "syncs left unseen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, NINT * P);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule